// File: doc/BRIEF.md
# Gear-Ratio Clock Divider and Rising-Edge Phase Comparator

This block sits between a memory controller clock and a memory channel clock that run at different frequencies. Each clock is divided in its own domain by a programmable integer ratio. The ratios are chosen so that both divided clocks share one frequency: the controller clock divided by its ratio equals the channel clock divided by its ratio. For example, 133 MHz over 4 and 100 MHz over 3 both give about 33 MHz. The two divided clocks leave the block as outputs, so that they can be routed to an external phase aligner's detector pins.

A phase comparator samples both divided clocks with a third, faster sampling clock. It looks only at rising edges, because the two divided clocks have different high times. When one divided clock rises first, it raises a direction output (`up` for controller first, `dn` for channel first). That output stays high until the other divided clock rises. A comparison whose edge gap does not exceed a programmable limit counts as good. A run of consecutive good comparisons raises `lock`.

A single asynchronous active-low reset clears all three domains. Deassertion is synchronised separately in each domain. This gives the two dividers a known starting point, so the first divided edges come out at a fixed count of input cycles.

Top module: `gear_phase_cmp`

## Requirements
- R1: While `rst_n` is low, `pclkm`, `synclkn`, `up`, `dn` and `lock` are all 0.
- R2: With a ratio R in 2..15 (4-bit field; a value below 2 acts as 2), each divided output has a period of exactly R rising edges of its input clock.
- R3: Each divided output stays high for floor(R/2) input cycles per period. An odd ratio therefore gives a high time shorter than half the period.
- R4: After `rst_n` goes high, a divided output first rises on the (R+2)-th rising edge of its input clock. Two of those edges are for reset synchronisation.
- R5: If `pclkm` rises before `synclkn`, `up` goes high; if `synclkn` rises first, `dn` goes high. The two are never high together. Rising edges seen in the same sample cycle raise neither. The decision is correct for any offset smaller than half the divided period.
- R6: A direction output stays high for exactly the rising-edge gap, measured in `smp_clk` cycles. Both divided clocks pass through equal two-stage synchronisers.
- R7: `lock` rises together with the end of the 16th consecutive comparison whose gap is at most `gap_limit`. It is 0 after the 15th such comparison. A comparison whose gap exceeds `gap_limit` clears the run and `lock`.
- R8: Falling edges of the divided clocks play no part. The measured gap equals the rising-edge gap even when the two high times differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Controller-side clock, divided by `m_ratio` |
| chan_clk | input | 1 | Channel-side clock, divided by `n_ratio` |
| smp_clk | input | 1 | Sampling clock for the phase comparator |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| m_ratio | input | 4 | Controller divide ratio (change only in reset) |
| n_ratio | input | 4 | Channel divide ratio (change only in reset) |
| gap_limit | input | 8 | Largest edge gap, in `smp_clk` cycles, counted as good |
| pclkm | output | 1 | Divided controller clock |
| synclkn | output | 1 | Divided channel clock |
| up | output | 1 | High while `pclkm` leads and `synclkn` has not yet risen |
| dn | output | 1 | High while `synclkn` leads and `pclkm` has not yet risen |
| lock | output | 1 | Run of good comparisons reached |

## Verification
Ratio pairs are run with both even and odd ratios. Controller and channel clock periods are picked so that the two high times differ, which separates a rising-edge comparator from one that reacts to any edge. Phase offsets are random multiples of the sampling period on both sides of zero, up to nearly half the divided period. This tests the sign decision and the pulse width against the exact offset. Directed cases add zero offset (no direction pulse, lock anyway), a gap one cycle above the limit (never locks), and a gap within the limit (lock exactly at the 16th comparison).

// File: rtl/gear_pkg.sv
`timescale 1ns/1ps
package gear_pkg;
  typedef enum logic [1:0] {
    CMP_IDLE     = 2'd0,
    CMP_WAIT_CH  = 2'd1,
    CMP_WAIT_CTL = 2'd2
  } cmp_state_e;
endpackage

// File: rtl/gear_rst_sync.sv
`timescale 1ns/1ps
module gear_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/gear_div.sv
`timescale 1ns/1ps
module gear_div #(
  parameter int RW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] ratio,
  output logic          div_out
);
  localparam logic [RW-1:0] MIN_RATIO = RW'(2);

  logic [RW-1:0] eff, half, ph_q, ph_d;
  logic          wrap, armed_q, armed_d, out_q, out_d;

  always_comb begin
    eff     = (ratio < MIN_RATIO) ? MIN_RATIO : ratio;
    half    = eff >> 1;
    wrap    = (ph_q == eff - RW'(1));
    ph_d    = wrap ? '0 : ph_q + RW'(1);
    armed_d = armed_q | wrap;
    out_d   = armed_d && (ph_d < half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q    <= '0;
      armed_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      armed_q <= armed_d;
      out_q   <= out_d;
    end
  end

  assign div_out = out_q;

  // R4: no output pulse before the first full ratio has elapsed
  a_r4_quiet_until_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |-> !out_q);
  // R2: every output rising edge lines up with the start of a count period
  a_r2_rise_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> (ph_q == '0));
endmodule

// File: rtl/gear_edge_sync.sv
`timescale 1ns/1ps
module gear_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/gear_pcmp.sv
`timescale 1ns/1ps
module gear_pcmp
  import gear_pkg::*;
#(
  parameter int GW     = 8,
  parameter int LOCK_N = 16,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_div,
  input  logic          ch_div,
  input  logic [GW-1:0] gap_limit,
  output logic          up,
  output logic          dn,
  output logic          lock
);
  localparam int LCW = $clog2(LOCK_N + 1);
  localparam logic [LCW-1:0] RUN_FULL = LCW'(LOCK_N);
  localparam logic [GW-1:0]  GAP_MAX  = {GW{1'b1}};

  logic          p_rise, s_rise, fin, miss;
  cmp_state_e    state_q, state_d;
  logic [GW-1:0] cnt_q, cnt_d, cnt_inc, gap;
  logic [LCW-1:0] good_q, good_d;
  logic          lock_q, lock_d;

  gear_edge_sync #(.STAGES(STAGES)) u_sync_ctl (
    .clk(clk), .rst_n(rst_n), .din(ctl_div), .rise(p_rise));
  gear_edge_sync #(.STAGES(STAGES)) u_sync_ch (
    .clk(clk), .rst_n(rst_n), .din(ch_div), .rise(s_rise));

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    good_d  = good_q;
    fin     = 1'b0;
    miss    = 1'b0;
    gap     = cnt_q;
    cnt_inc = (cnt_q == GAP_MAX) ? cnt_q : cnt_q + GW'(1);
    unique case (state_q)
      CMP_IDLE: begin
        if (p_rise && s_rise) begin
          fin = 1'b1;
          gap = '0;
        end else if (p_rise) begin
          state_d = CMP_WAIT_CH;
          cnt_d   = GW'(1);
        end else if (s_rise) begin
          state_d = CMP_WAIT_CTL;
          cnt_d   = GW'(1);
        end
      end
      CMP_WAIT_CH: begin
        if (s_rise) begin
          fin     = 1'b1;
          state_d = CMP_IDLE;
        end else if (p_rise) begin
          miss  = 1'b1;
          cnt_d = GW'(1);
        end else begin
          cnt_d = cnt_inc;
        end
      end
      CMP_WAIT_CTL: begin
        if (p_rise) begin
          fin     = 1'b1;
          state_d = CMP_IDLE;
        end else if (s_rise) begin
          miss  = 1'b1;
          cnt_d = GW'(1);
        end else begin
          cnt_d = cnt_inc;
        end
      end
      default: state_d = CMP_IDLE;
    endcase
    if (fin) begin
      if (gap <= gap_limit) good_d = (good_q == RUN_FULL) ? good_q : good_q + LCW'(1);
      else                  good_d = '0;
    end
    if (miss) good_d = '0;
    lock_d = (good_d == RUN_FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CMP_IDLE;
      cnt_q   <= '0;
      good_q  <= '0;
      lock_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      good_q  <= good_d;
      lock_q  <= lock_d;
    end
  end

  assign up   = (state_q == CMP_WAIT_CH);
  assign dn   = (state_q == CMP_WAIT_CTL);
  assign lock = lock_q;

  // R5: direction outputs are mutually exclusive
  a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));
  // R5: up only starts on a controller-side rising edge
  a_r5_up_from_ctl: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(up) |-> $past(p_rise));
  // R6: a lagging channel edge ends the up pulse
  a_r6_lag_clears_up: assert property (@(posedge clk) disable iff (!rst_n)
    (up && s_rise) |=> !up);
  // R7: lock only appears as a comparison completes
  a_r7_lock_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(p_rise || s_rise));
endmodule

// File: rtl/gear_phase_cmp.sv
`timescale 1ns/1ps
module gear_phase_cmp #(
  parameter int RW     = 4,
  parameter int GW     = 8,
  parameter int LOCK_N = 16
) (
  input  logic          ctl_clk,
  input  logic          chan_clk,
  input  logic          smp_clk,
  input  logic          rst_n,
  input  logic [RW-1:0] m_ratio,
  input  logic [RW-1:0] n_ratio,
  input  logic [GW-1:0] gap_limit,
  output logic          pclkm,
  output logic          synclkn,
  output logic          up,
  output logic          dn,
  output logic          lock
);
  logic ctl_rst_n, ch_rst_n, smp_rst_n;

  gear_rst_sync u_rs_ctl (.clk(ctl_clk),  .arst_n(rst_n), .srst_n(ctl_rst_n));
  gear_rst_sync u_rs_ch  (.clk(chan_clk), .arst_n(rst_n), .srst_n(ch_rst_n));
  gear_rst_sync u_rs_smp (.clk(smp_clk),  .arst_n(rst_n), .srst_n(smp_rst_n));

  gear_div #(.RW(RW)) u_div_ctl (
    .clk(ctl_clk), .rst_n(ctl_rst_n), .ratio(m_ratio), .div_out(pclkm));
  gear_div #(.RW(RW)) u_div_ch (
    .clk(chan_clk), .rst_n(ch_rst_n), .ratio(n_ratio), .div_out(synclkn));

  gear_pcmp #(.GW(GW), .LOCK_N(LOCK_N)) u_cmp (
    .clk(smp_clk), .rst_n(smp_rst_n), .ctl_div(pclkm), .ch_div(synclkn),
    .gap_limit(gap_limit), .up(up), .dn(dn), .lock(lock));
endmodule

// File: tb/gear_phase_cmp_test.sv
`timescale 1ns/1ps
module gear_phase_cmp_test;
  logic smp_clk = 1'b0, ctl_clk = 1'b0, chan_clk = 1'b0, rst_n = 1'b0;
  logic [3:0] m_r = 4'd2, n_r = 4'd2;
  logic [7:0] lim = 8'd0;
  logic pclkm, synclkn, up, dn, lock;
  int tests = 0, fails = 0;
  int tp = 40, ts = 40;
  bit p_run = 1'b0, s_run = 1'b0, done = 1'b0;
  int pcnt = 0, scnt = 0;

  int cm [6] = '{2, 4, 4, 4, 3, 6};
  int cn [6] = '{2, 4, 2, 3, 2, 4};
  int ctp[6] = '{40, 20, 20, 30, 40, 20};
  int cts[6] = '{40, 20, 40, 40, 60, 30};

  gear_phase_cmp uut (
    .ctl_clk(ctl_clk), .chan_clk(chan_clk), .smp_clk(smp_clk), .rst_n(rst_n),
    .m_ratio(m_r), .n_ratio(n_r), .gap_limit(lim),
    .pclkm(pclkm), .synclkn(synclkn), .up(up), .dn(dn), .lock(lock));

  always #2.5 smp_clk = ~smp_clk;
  always begin
    wait (p_run);
    ctl_clk = 1'b1; #(tp * 0.5); ctl_clk = 1'b0; #(tp * 0.5);
  end
  always begin
    wait (s_run);
    chan_clk = 1'b1; #(ts * 0.5); chan_clk = 1'b0; #(ts * 0.5);
  end
  always @(posedge ctl_clk)  pcnt++;
  always @(posedge chan_clk) scnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_first(input int r); return r + 2; endfunction
  function automatic int exp_high(input int r);  return r / 2;  endfunction
  function automatic bit exp_good(input int g, input int l); return g <= l; endfunction

  task automatic watch_cmp(input int d, input int limit, input int per);
    int g = (d < 0) ? -d / 5 : d / 5;
    bit good = exp_good(g, limit);
    if (d == 0) begin
      bit seen = 1'b0;
      repeat ((20 * per + 400) / 5) begin
        @(negedge smp_clk);
        if (up || dn) seen = 1'b1;
      end
      chk(!seen, "R5 aligned edges no direction", int'(seen), 0);
      chk(lock == 1'b1, "R7 lock at zero gap", int'(lock), 1);
    end else begin
      bit prev = 1'b0, cur;
      int falls = 0, w = 0;
      while (!((good && falls >= 16) || (!good && falls >= 20))) begin
        @(negedge smp_clk);
        cur = up | dn;
        if (cur && !prev && falls == 0)
          chk(up == (d > 0) && dn == (d < 0), "R5 sign", int'({up, dn}),
              (d > 0) ? 2 : 1);
        if (cur && falls == 0) w++;
        if (prev && !cur) begin
          falls++;
          if (falls == 1) chk(w == g, "R6/R8 pulse width", w, g);
          if (good && falls == 15) chk(lock == 1'b0, "R7 no lock at 15", int'(lock), 0);
          if (good && falls == 16) chk(lock == 1'b1, "R7 lock at 16", int'(lock), 1);
          if (!good && falls == 20) chk(lock == 1'b0, "R7 gap over limit", int'(lock), 0);
        end
        prev = cur;
      end
    end
  endtask

  task automatic run_case(input int ci, input int d, input int limit);
    int mm = cm[ci], nn = cn[ci], per, x, offp, offs, p0, s0, a, b, c;
    p_run = 1'b0; s_run = 1'b0; rst_n = 1'b0;
    m_r = 4'(mm); n_r = 4'(nn); lim = 8'(limit);
    tp = ctp[ci]; ts = cts[ci];
    per = mm * tp;
    #300;
    @(negedge smp_clk);
    chk(!pclkm && !synclkn, "R1 divided outputs in reset", int'({pclkm, synclkn}), 0);
    chk(!up && !dn && !lock, "R1 comparator outputs in reset", int'({up, dn, lock}), 0);
    @(posedge smp_clk); #1;
    rst_n = 1'b1;
    x = (mm + 1) * tp - (nn + 1) * ts + d;
    offp = (x < 0) ? -x : 0;
    offs = (x < 0) ? 0 : x;
    p0 = pcnt; s0 = scnt;
    fork
      begin #(offp); p_run = 1'b1; end
      begin #(offs); s_run = 1'b1; end
      begin @(posedge pclkm); chk(pcnt - p0 == exp_first(mm), "R4 first pclkm edge", pcnt - p0, exp_first(mm)); end
      begin @(posedge synclkn); chk(scnt - s0 == exp_first(nn), "R4 first synclkn edge", scnt - s0, exp_first(nn)); end
      begin watch_cmp(d, limit, per); end
    join
    @(posedge pclkm); a = pcnt; @(negedge pclkm); b = pcnt; @(posedge pclkm); c = pcnt;
    chk(b - a == exp_high(mm), "R3 pclkm high time", b - a, exp_high(mm));
    chk(c - a == mm, "R2 pclkm period", c - a, mm);
    @(posedge synclkn); a = scnt; @(negedge synclkn); b = scnt; @(posedge synclkn); c = scnt;
    chk(b - a == exp_high(nn), "R3 synclkn high time", b - a, exp_high(nn));
    chk(c - a == nn, "R2 synclkn period", c - a, nn);
  endtask

  initial begin
    void'($urandom(32'd20511));
    // directed corners
    run_case(0, 0, 0);      // zero offset: no direction, lock
    run_case(4, 15, 3);     // odd ratio, gap 3 within limit
    run_case(3, -25, 4);    // channel leads, gap 5 over limit
    run_case(1, 5, 0);      // one cycle over a zero limit
    run_case(5, -50, 10);   // channel leads by 10 cycles, locks
    // constrained random
    for (int i = 0; i < 8; i++) begin
      int ci = int'($urandom % 6);
      int per = cm[ci] * ctp[ci];
      int steps = (per / 2 - 10) / 5;
      int d = 5 * (int'($urandom % (2 * steps + 1)) - steps);
      int l = int'($urandom % 5);
      run_case(ci, d, l);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #600000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R7: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule